// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter with Character Queue

This block is the sending half of an asynchronous serial port. A single-cycle write strobe places an 8-bit character into a small first-in first-out queue. A shift engine takes characters from the queue one at a time and sends each one on the serial output as a frame. The frame starts with a low start bit and carries the data least significant bit first. An even or odd parity bit may follow the data. The frame closes with one or two high stop bits. A one-cycle baud tick from an external rate generator sets the pace of every bit.

When hardware handshaking is switched on, the engine starts a new character only while the active-low clear-to-send input, after synchronization, reads low. A character that is already on the line always finishes. The ports also report whether the queue is empty or full, whether a write was ever lost, and whether a frame is in progress.

Top module: `uart_flow_tx`

## Requirements
- R1: The serial output `txd` rests at 1 when idle. Each frame is one 0 start bit, then 8 data bits with bit 0 first, then the stop bit(s) at 1.
- R2: When `cfg_parity_en` is 1, a parity bit follows data bit 7. With `cfg_parity_odd` = 0 it makes the count of ones over the data plus parity even; with 1 it makes that count odd. The configuration is captured when the start bit begins.
- R3: `cfg_two_stop` = 1 sends two stop bits and 0 sends one. The value is captured when the start bit begins.
- R4: `txd` changes only in the cycle after a cycle with `baud_tick` = 1, so every bit lasts exactly one tick period.
- R5: When the queue holds a character and sending is allowed, its start bit follows the last stop bit of the previous frame with no idle bit between them.
- R6: The queue holds 4 characters and sends them in write order. `fifo_empty` and `fifo_full` report its state.
- R7: A write while `fifo_full` is 1 is dropped and sets `overflow`, which stays at 1 until reset.
- R8: With `cfg_flow_en` = 1, no new frame starts while the synchronized `cts_n` is 1.
- R9: When `cts_n` goes to 1 during a frame, that frame still completes, including its parity and stop bits.
- R10: With `cfg_flow_en` = 0, `cts_n` has no effect and frames start whenever the queue is non-empty.
- R11: `busy` is 1 from the start bit through the full period of the last stop bit, and 0 when the line is idle.
- R12: After a synchronous reset, `txd`=1, `busy`=0, `fifo_empty`=1, `fifo_full`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse that ends each bit period |
| wr_en | input | 1 | Write strobe for the character queue |
| wr_data | input | 8 | Character to queue |
| cfg_flow_en | input | 1 | Enables clear-to-send gating |
| cfg_parity_en | input | 1 | Adds a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| txd | output | 1 | Serial data output |
| busy | output | 1 | A frame is in progress |
| fifo_empty | output | 1 | The queue holds no character |
| fifo_full | output | 1 | The queue holds 4 characters |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench builds the block with its default parameters: a queue depth of 4 and a two-stage synchronizer. It drives a baud tick every fourth clock. With depth 4, the full flag and the dropped write are reached after only five writes while handshaking holds the engine idle. The short tick period lets many frames and all parity and stop-bit settings run within the cycle budget. Because the synchronizer is short, a deassertion of `cts_n` can be placed clearly inside a frame to show that the frame is not cut short.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_e;

    // Frame settings captured when the start bit begins
    typedef struct packed {
        logic par_en;
        logic par_bit;
        logic two_stop;
    } frame_cfg_t;

    function automatic logic calc_parity(input logic [CHAR_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/tx_char_fifo.sv
module tx_char_fifo
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              pop,
    output logic [CHAR_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CHAR_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              push, take;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign push  = wr_en && !full;
    assign take  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (take) rd_ptr <= bump(rd_ptr);
            case ({push, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    AST_FIFO_BOUND:   assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R6
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R6
    AST_FULL_DROP:    assert property (@(posedge clk) disable iff (rst) (wr_en && full && !pop) |=> full); // R7
    AST_OVF_STICKY:   assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R7

endmodule

// File: rtl/cts_synchronizer.sv
module cts_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              avail,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              flow_en,
    input  logic              cts_n_sync,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int IW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

    tx_state_e         state;
    frame_cfg_t        fcfg;
    logic [CHAR_W-1:0] shreg;
    logic [IW-1:0]     bit_idx;
    logic              can_start, at_boundary;

    assign can_start   = avail && (!flow_en || !cts_n_sync);
    assign at_boundary = (state == TX_IDLE) || (state == TX_STOP2) ||
                         (state == TX_STOP1 && !fcfg.two_stop);
    assign pop  = baud_tick && at_boundary && can_start;
    assign busy = (state != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            fcfg    <= '0;
            shreg   <= '0;
            bit_idx <= '0;
        end else if (baud_tick) begin
            if (pop) begin
                state <= TX_START;
                shreg <= char_in;
                fcfg  <= '{par_en: par_en, par_bit: calc_parity(char_in, par_odd), two_stop: two_stop};
            end else begin
                case (state)
                    TX_START: begin
                        state   <= TX_DATA;
                        bit_idx <= '0;
                    end
                    TX_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == IW'(CHAR_W - 1))
                            state <= fcfg.par_en ? TX_PARITY : TX_STOP1;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end
                    TX_PARITY: state <= TX_STOP1;
                    TX_STOP1:  state <= fcfg.two_stop ? TX_STOP2 : TX_IDLE;
                    default:   state <= TX_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = fcfg.par_bit;
            default:   txd = 1'b1;
        endcase
    end

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst) !$stable(txd) |-> $past(baud_tick)); // R4
    AST_CTS_BLOCKS:   assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && flow_en && cts_n_sync) |=> (state == TX_IDLE)); // R8
    AST_NO_TRUNCATE:  assert property (@(posedge clk) disable iff (rst)
        (state == TX_START || state == TX_DATA || state == TX_PARITY) |=> busy); // R9

endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              cfg_flow_en,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              cts_n,
    output logic              txd,
    output logic              busy,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overflow
);
    logic [CHAR_W-1:0] head_char;
    logic              pop, cts_n_sync;

    tx_char_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .rd_data(head_char), .empty(fifo_empty), .full(fifo_full), .overflow(overflow)
    );

    cts_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(cts_n), .sync_out(cts_n_sync)
    );

    tx_frame_engine u_engine (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .avail(!fifo_empty),
        .char_in(head_char), .flow_en(cfg_flow_en), .cts_n_sync(cts_n_sync),
        .par_en(cfg_parity_en), .par_odd(cfg_parity_odd), .two_stop(cfg_two_stop),
        .pop(pop), .txd(txd), .busy(busy)
    );

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !txd); // R11
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !busy |-> txd); // R1

endmodule

// File: tb/tb_uart_flow_tx.sv
module tb_uart_flow_tx;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_flow_en = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd, busy, fifo_empty, fifo_full, overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_flow_tx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_flow_en(cfg_flow_en), .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .cts_n(cts_n), .txd(txd), .busy(busy),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
    );

    task automatic chk(input logic ok, input string tag, input string what);
        checks++;
        if (ok !== 1'b1) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input logic odd);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        return ((ones % 2) == 1) ^ odd;
    endfunction

    // Line decoder: samples the bit held during each tick period
    logic [7:0] rx_data[$];
    int         rx_gap[$];
    int         div_cnt = 0;
    int         dec_st = 0, dec_idx = 0, gap = 99, cur_gap = 0;
    logic [7:0] dec_sh;
    logic       txd_prev = 1'b1;

    task automatic decode(input logic b);
        case (dec_st)
            0: begin
                if (b == 1'b0) begin
                    dec_st = 1; dec_idx = 0; cur_gap = gap;
                    chk(busy, "R11", $sformatf("busy actual %b expected 1 at start bit", busy));
                end else begin
                    gap++;
                    chk(!busy, "R11", $sformatf("busy actual %b expected 0 while idle", busy));
                end
            end
            1: begin
                dec_sh[dec_idx] = b;
                dec_idx++;
                if (dec_idx == 8) dec_st = cfg_parity_en ? 2 : 3;
            end
            2: begin
                chk(b == exp_parity(dec_sh, cfg_parity_odd), "R2",
                    $sformatf("parity actual %b expected %b", b, exp_parity(dec_sh, cfg_parity_odd)));
                dec_st = 3;
            end
            default: begin
                chk(b == 1'b1, "R3", $sformatf("stop bit actual %b expected 1", b));
                chk(busy, "R11", $sformatf("busy in stop actual %b expected 1", busy));
                if (dec_st == 3 && cfg_two_stop) dec_st = 4;
                else begin
                    rx_data.push_back(dec_sh);
                    rx_gap.push_back(cur_gap);
                    dec_st = 0; gap = 0;
                end
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (rst) begin
            dec_st = 0; gap = 99;
        end else begin
            if (txd !== txd_prev)
                chk(baud_tick, "R4", $sformatf("txd moved without tick: tick actual %b expected 1", baud_tick));
            if (div_cnt == DIV - 1) decode(txd);
        end
        txd_prev = txd;
        if (div_cnt == DIV - 1) begin
            baud_tick <= 1'b1; div_cnt = 0;
        end else begin
            baud_tick <= 1'b0; div_cnt++;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rx_data.delete(); rx_gap.delete();
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (fifo_empty && !busy) break;
        end
    endtask

    task automatic compare(input logic [7:0] exp[$], input string tag);
        chk(rx_data.size() == exp.size(), tag,
            $sformatf("frame count actual %0d expected %0d", rx_data.size(), exp.size()));
        for (int i = 0; i < exp.size() && i < rx_data.size(); i++)
            chk(rx_data[i] == exp[i], tag, $sformatf("char %0d actual %h expected %h", i, rx_data[i], exp[i]));
        rx_data.delete(); rx_gap.delete();
    endtask

    initial begin
        automatic logic [7:0] exp[$];
        automatic logic [7:0] b;
        void'($urandom(32'd20240611));
        do_reset();
        // R12 reset state
        chk(txd == 1'b1, "R12", $sformatf("txd actual %b expected 1", txd));
        chk(busy == 1'b0, "R12", $sformatf("busy actual %b expected 0", busy));
        chk(fifo_empty == 1'b1, "R12", $sformatf("empty actual %b expected 1", fifo_empty));
        chk(fifo_full == 1'b0, "R12", $sformatf("full actual %b expected 0", fifo_full));
        chk(overflow == 1'b0, "R12", $sformatf("overflow actual %b expected 0", overflow));

        // R1 R2 R5: three queued characters, even parity, must run back to back
        cfg_parity_en = 1; cfg_parity_odd = 0; cfg_two_stop = 0;
        exp = '{8'h5A, 8'h01, 8'hFF};
        foreach (exp[i]) push(exp[i]);
        wait_idle();
        chk(rx_gap.size() == 3 && rx_gap[1] == 0 && rx_gap[2] == 0, "R5",
            $sformatf("gaps actual %p expected 0 between frames", rx_gap));
        compare(exp, "R1");

        // R2 R3: odd parity with two stop bits
        cfg_parity_odd = 1; cfg_two_stop = 1;
        exp = '{8'hA5, 8'h80};
        foreach (exp[i]) push(exp[i]);
        wait_idle();
        compare(exp, "R3");

        // R10: handshake disabled, cts_n high has no effect
        cfg_flow_en = 0; cts_n = 1; cfg_parity_en = 0; cfg_two_stop = 0;
        exp = '{8'h3C, 8'hC3};
        foreach (exp[i]) push(exp[i]);
        wait_idle();
        compare(exp, "R10");

        // R8: handshake enabled and cts_n high holds the character
        cfg_flow_en = 1; cts_n = 1;
        repeat (4) @(negedge clk);
        push(8'h77);
        repeat (80) @(negedge clk);
        chk(rx_data.size() == 0, "R8", $sformatf("frames actual %0d expected 0", rx_data.size()));
        chk(busy == 0 && txd == 1, "R8", $sformatf("busy/txd actual %b%b expected 01", busy, txd));
        chk(fifo_empty == 0, "R8", $sformatf("empty actual %b expected 0", fifo_empty));
        cts_n = 0;
        wait_idle();
        exp = '{8'h77};
        compare(exp, "R8");

        // R9: cts_n rises mid-frame; the frame completes and the next waits
        cfg_parity_en = 1; cfg_two_stop = 1;
        push(8'h11); push(8'h22);
        for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
        repeat (5 * DIV) @(negedge clk);
        cts_n = 1;
        repeat (160) @(negedge clk);
        exp = '{8'h11};
        compare(exp, "R9");
        chk(fifo_empty == 0 && busy == 0, "R9",
            $sformatf("empty/busy actual %b%b expected 00", fifo_empty, busy));
        cts_n = 0;
        wait_idle();
        exp = '{8'h22};
        compare(exp, "R8");

        // R6 R7: fill while blocked, overflow, then drain in order
        do_reset();
        cfg_flow_en = 1; cts_n = 1; cfg_parity_en = 0; cfg_two_stop = 0;
        repeat (4) @(negedge clk);
        exp = '{8'hD1, 8'hD2, 8'hD3, 8'hD4};
        foreach (exp[i]) push(exp[i]);
        chk(fifo_full == 1 && overflow == 0, "R6",
            $sformatf("full/overflow actual %b%b expected 10", fifo_full, overflow));
        push(8'hEE);
        chk(overflow == 1 && fifo_full == 1, "R7",
            $sformatf("full/overflow actual %b%b expected 11", fifo_full, overflow));
        cts_n = 0;
        wait_idle();
        compare(exp, "R6");
        chk(overflow == 1, "R7", $sformatf("sticky overflow actual %b expected 1", overflow));
        do_reset();
        chk(overflow == 0, "R12", $sformatf("overflow after reset actual %b expected 0", overflow));

        // Random batches with random frame settings
        for (int batch = 0; batch < 40; batch++) begin
            automatic int n = 1 + int'($urandom_range(0, 5));
            cfg_flow_en    = 1'($urandom_range(0, 1));
            cts_n          = cfg_flow_en ? 1'b0 : 1'($urandom_range(0, 1));
            cfg_parity_en  = 1'($urandom_range(0, 1));
            cfg_parity_odd = 1'($urandom_range(0, 1));
            cfg_two_stop   = 1'($urandom_range(0, 1));
            exp.delete();
            for (int k = 0; k < n; k++) begin
                while (fifo_full) @(negedge clk);
                b = 8'($urandom);
                exp.push_back(b);
                push(b);
                repeat ($urandom_range(0, 3)) @(negedge clk);
            end
            wait_idle();
            compare(exp, "R6");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run actual unfinished expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule